// File: doc/BRIEF.md
# Grouped-Prescale Down-Counting PWM Timer

The block holds five timer channels that run from one peripheral clock. Channels 0 to 3 each drive a PWM pin. Channel 4 is an internal countdown timer. It has no compare stage and no pin. Each channel counts down at a tick rate set by two stages:

- an 8-bit prescaler shared by a fixed group of channels;
- a per-channel power-of-two divider.

Software programs a count buffer and a compare buffer for a channel. Neither buffer affects the running counter until it is loaded. A load happens in two ways:

- holding the channel's manual-update bit high, then clearing it;
- auto-reload, when the counter underflows.

A period lasts N+1 ticks for a count value N. The output is high while the counter is above the compare value. A duty of D ticks is therefore programmed with compare = N - D. Each channel has an invert bit that flips the output level.

Every channel emits a one-cycle expiry pulse each time its counter underflows. With auto-reload clear, the channel expires once and then parks at zero until the next manual update. Clearing the start bit freezes the counter. The output keeps its level while the counter is frozen.

Top module: `pwm_timer`

## Requirements
- R1: After reset every register word reads 0, every PWM output is low and every expiry output is low.
- R2: Word 0 holds two prescale values. Bits 7:0 serve channels 0 and 1. Bits 15:8 serve channels 2, 3 and 4. Word 1 holds a 4-bit divider select per channel, channel n at bits 4n+3:4n. One tick of a channel lasts (prescale+1)·2^select clock cycles.
- R3: With auto-reload set and count value N, consecutive expiry pulses of a channel are (N+1) ticks apart.
- R4: With compare value C (C ≤ N), a non-inverted output is high for N-C ticks of each period and low for the remaining C+1 ticks.
- R5: Writing a count or compare buffer leaves the active counter unchanged. While the manual-update bit is high, the active counter and compare follow the buffers and no counting occurs.
- R6: With auto-reload clear, a started channel produces exactly one expiry pulse. After that pulse the counter stays at 0 until the next manual update.
- R7: Clearing the start bit freezes the counter and holds the output level.
- R8: The invert bit flips the PWM level on channels 0 to 3. Channel 4's invert bit (word 2 bit 18) is not writable and reads 0.
- R9: Channel 4 with an all-ones count buffer runs as a free-running countdown with a period of 2^CNT_W ticks.
- R10: Each expiry pulse lasts one clock cycle when the tick period is longer than one cycle.
- R11: The count buffer of channel n is at word 3+3n and the compare buffer at word 4+3n. The active counter reads back, read-only, at word 5+3n. Word 16, channel 4's compare slot, reads 0 and ignores writes.
- R12: Word 2 gives channel n the bits 4n+3:4n. Within that field, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable, one cycle per write |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwm_o | output | NPIN | PWM outputs of channels 0 to 3 |
| expire_o | output | NCH | One-cycle underflow pulse per channel |

## Verification
The assertions check the following on every cycle:

- a stopped channel's counter never moves;
- a held manual update loads the counter from its buffer;
- an expiry pulse only follows a counter at zero;
- a channel ticks only on its group's prescaler tick;
- a finished one-shot stays parked at zero.

Some behaviour only the bench scenarios can show. These are the exact period and duty in clock cycles across the prescale, divider, count and compare sweep, inversion, and the prescaler grouping between channels. They also cover the register map layout, read-back masking and the full-length countdown of channel 4.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int NCH       = 5;
  localparam int NPIN      = 4;
  localparam int FLD_W     = 4;
  localparam int ADR_PRE   = 0;
  localparam int ADR_DIV   = 1;
  localparam int ADR_CTL   = 2;
  localparam int CH_BASE   = 3;
  localparam int CH_STRIDE = 3;
  localparam int CB_START  = 0;
  localparam int CB_UPD    = 1;
  localparam int CB_INV    = 2;
  localparam int CB_RLD    = 3;

  function automatic int grp_of(input int ch);
    return (ch < 2) ? 0 : 1;
  endfunction

  function automatic int adr_cnt_buf(input int ch);
    return CH_BASE + CH_STRIDE * ch;
  endfunction

  function automatic int adr_cmp_buf(input int ch);
    return CH_BASE + CH_STRIDE * ch + 1;
  endfunction

  function automatic int adr_cnt_obs(input int ch);
    return CH_BASE + CH_STRIDE * ch + 2;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] pre_val_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= pre_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DW = (2 ** SEL_W) - 1;

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] lim;

  // 2^sel - 1; sel at max wraps to all ones, still correct
  assign lim    = (DW'(1) << sel_i) - DW'(1);
  assign tick_o = pre_tick_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (tick_o)     cnt_q <= '0;
    else if (pre_tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W   = 16,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             upd_i,
  input  logic             rld_i,
  input  logic             inv_i,
  input  logic [CNT_W-1:0] cbuf_i,
  input  logic [CNT_W-1:0] mbuf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o,
  output logic             expire_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             done_q;
  logic             run;

  assign run = start_i && !done_q && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      exp_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (upd_i) begin
      cnt_q  <= cbuf_i;
      exp_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (run) begin
      if (cnt_q == '0) begin
        exp_q <= 1'b1;
        if (rld_i) cnt_q  <= cbuf_i;
        else       done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        exp_q <= 1'b0;
      end
    end else begin
      exp_q <= 1'b0;
    end
  end

  generate
    if (HAS_CMP) begin : g_cmp
      logic [CNT_W-1:0] cmp_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cmp_q <= '0;
        else if (upd_i || (run && rld_i && cnt_q == '0)) cmp_q <= mbuf_i;
      end
      // high while above compare: N-C ticks of N+1
      assign pwm_o = (cnt_q > cmp_q) ^ inv_i;
    end else begin : g_nocmp
      logic unused_cmp;
      assign unused_cmp = inv_i ^ (^mbuf_i);
      assign pwm_o      = 1'b0;
    end
  endgenerate

  assign cnt_o    = cnt_q;
  assign expire_o = exp_q;
  assign done_o   = done_q;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  output logic [31:0]       rdata_o,
  output logic [NPIN-1:0]   pwm_o,
  output logic [NCH-1:0]    expire_o
);
  localparam int PRE_ALL = 2 * PRE_W;
  localparam int DIV_ALL = NCH * SEL_W;
  localparam int CTL_ALL = NCH * FLD_W;

  function automatic logic [CTL_ALL-1:0] ctl_wmask();
    logic [CTL_ALL-1:0] m;
    m = '1;
    for (int c = NPIN; c < NCH; c++) m[c*FLD_W+CB_INV] = 1'b0;
    return m;
  endfunction
  localparam logic [CTL_ALL-1:0] CTL_WMASK = ctl_wmask();

  logic [PRE_ALL-1:0]          pre_q;
  logic [DIV_ALL-1:0]          div_q;
  logic [CTL_ALL-1:0]          ctl_q;
  logic [NCH-1:0][CNT_W-1:0]   cbuf_q;
  logic [NPIN-1:0][CNT_W-1:0]  mbuf_q;
  logic [NCH-1:0][CNT_W-1:0]   cnt_all;
  logic [NCH-1:0]              ch_tick, ch_start, ch_upd, ch_rld, ch_inv, ch_done;
  logic [NCH-1:0]              ch_pwm;
  logic [1:0]                  grp_tick;
  logic                        unused_w;

  assign unused_w = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      div_q  <= '0;
      ctl_q  <= '0;
      cbuf_q <= '0;
      mbuf_q <= '0;
    end else if (we_i) begin
      if (int'(addr_i) == ADR_PRE) pre_q <= wdata_i[PRE_ALL-1:0];
      if (int'(addr_i) == ADR_DIV) div_q <= wdata_i[DIV_ALL-1:0];
      if (int'(addr_i) == ADR_CTL) ctl_q <= wdata_i[CTL_ALL-1:0] & CTL_WMASK;
      for (int c = 0; c < NCH; c++) begin
        if (int'(addr_i) == adr_cnt_buf(c)) cbuf_q[c] <= wdata_i[CNT_W-1:0];
      end
      for (int c = 0; c < NPIN; c++) begin
        if (int'(addr_i) == adr_cmp_buf(c)) mbuf_q[c] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) == ADR_PRE) rdata_o[PRE_ALL-1:0] = pre_q;
    if (int'(addr_i) == ADR_DIV) rdata_o[DIV_ALL-1:0] = div_q;
    if (int'(addr_i) == ADR_CTL) rdata_o[CTL_ALL-1:0] = ctl_q;
    for (int c = 0; c < NCH; c++) begin
      if (int'(addr_i) == adr_cnt_buf(c)) rdata_o[CNT_W-1:0] = cbuf_q[c];
      if (int'(addr_i) == adr_cnt_obs(c)) rdata_o[CNT_W-1:0] = cnt_all[c];
    end
    for (int c = 0; c < NPIN; c++) begin
      if (int'(addr_i) == adr_cmp_buf(c)) rdata_o[CNT_W-1:0] = mbuf_q[c];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_grp
    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pre_val_i (pre_q[g*PRE_W +: PRE_W]),
      .tick_o    (grp_tick[g])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam bit HAS_PIN = (c < NPIN);
    logic [CNT_W-1:0] mbuf;

    assign ch_start[c] = ctl_q[c*FLD_W+CB_START];
    assign ch_upd[c]   = ctl_q[c*FLD_W+CB_UPD];
    assign ch_inv[c]   = ctl_q[c*FLD_W+CB_INV];
    assign ch_rld[c]   = ctl_q[c*FLD_W+CB_RLD];

    if (HAS_PIN) begin : g_pin
      assign mbuf     = mbuf_q[c];
      assign pwm_o[c] = ch_pwm[c];
    end else begin : g_nopin
      logic unused_pwm;
      assign mbuf       = '0;
      assign unused_pwm = ch_pwm[c];
    end

    pwm_tick_div #(.SEL_W(SEL_W)) u_div (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pre_tick_i (grp_tick[grp_of(c)]),
      .sel_i      (div_q[c*SEL_W +: SEL_W]),
      .tick_o     (ch_tick[c])
    );

    pwm_chan #(.CNT_W(CNT_W), .HAS_CMP(HAS_PIN)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (ch_tick[c]),
      .start_i  (ch_start[c]),
      .upd_i    (ch_upd[c]),
      .rld_i    (ch_rld[c]),
      .inv_i    (ch_inv[c]),
      .cbuf_i   (cbuf_q[c]),
      .mbuf_i   (mbuf),
      .cnt_o    (cnt_all[c]),
      .pwm_o    (ch_pwm[c]),
      .expire_o (expire_o[c]),
      .done_o   (ch_done[c])
    );
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NCH-1:0]            expire_o,
  input logic [NCH-1:0][CNT_W-1:0] cnt_all,
  input logic [NCH-1:0][CNT_W-1:0] cbuf_q,
  input logic [NCH-1:0]            ch_tick,
  input logic [NCH-1:0]            ch_start,
  input logic [NCH-1:0]            ch_upd,
  input logic [NCH-1:0]            ch_done,
  input logic [1:0]                grp_tick
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ch_start[c] && !ch_upd[c]) |=> $stable(cnt_all[c]));

    a_r5_update_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_upd[c] |=> (cnt_all[c] == $past(cbuf_q[c])));

    a_r3_expire_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o[c] |-> ($past(cnt_all[c]) == '0));

    a_r2_tick_in_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_tick[c] |-> grp_tick[grp_of(c)]);

    a_r6_oneshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_done[c] && !ch_upd[c]) |=> (cnt_all[c] == '0 && !expire_o[c]));
  end
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_pwm_timer_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .expire_o (expire_o),
  .cnt_all  (cnt_all),
  .cbuf_q   (cbuf_q),
  .ch_tick  (ch_tick),
  .ch_start (ch_start),
  .ch_upd   (ch_upd),
  .ch_done  (ch_done),
  .grp_tick (grp_tick)
);

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;
  localparam int CNT_W  = 10;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic              we = 1'b0;
  logic [31:0]       rdata;
  logic [3:0]        pwm;
  logic [4:0]        expire;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwm_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_pwm_timer (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .pwm_o(pwm), .expire_o(expire)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1 d = rdata;
  endtask

  task automatic wait_exp(input int ch, output bit ok);
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (expire[ch]) begin ok = 1; break; end
    end
  endtask

  // from one pulse to the next: cycles and cycles with pin high
  task automatic measure(input int ch, output int per, output int hi);
    bit ok;
    per = 0; hi = 0;
    wait_exp(ch, ok);
    if (!ok) begin per = -1; return; end
    do begin
      if (ch < 4 && pwm[ch]) hi++;
      per++;
      @(negedge clk);
    end while (!expire[ch] && per < 20000);
  endtask

  function automatic int fld(input int ch, input int v);
    return v << (4 * ch);
  endfunction

  initial begin
    int d, per, hi, tp, cnt_a, cnt_b, npulse;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 18; a++) begin
      rd(a, d);
      chk("R1", $sformatf("word %0d", a), d, 0);
    end
    chk("R1", "pwm after reset", int'(pwm), 0);
    chk("R1", "expire after reset", int'(expire), 0);

    // R11 R5 double buffering
    wr(3 + 3*1, 7);
    wr(4 + 3*1, 3);
    rd(3 + 3*1, d); chk("R11", "ch1 count buffer readback", d, 7);
    rd(4 + 3*1, d); chk("R11", "ch1 compare buffer readback", d, 3);
    rd(5 + 3*1, d); chk("R5", "counter untouched by buffer write", d, 0);
    wr(2, fld(1, 4'b0010));
    rd(5 + 3*1, d); chk("R5", "counter loaded under update", d, 7);
    wr(3 + 3*1, 9);
    rd(5 + 3*1, d); chk("R5", "counter tracks buffer while update held", d, 9);
    wr(2, 0);
    wr(16, 55);
    rd(16, d); chk("R11", "ch4 compare slot reads 0", d, 0);

    // R7 freeze: run ch1 then stop
    wr(0, 0); wr(1, 0);
    wr(3 + 3*1, 200); wr(4 + 3*1, 100);
    wr(2, fld(1, 4'b1010));
    wr(2, fld(1, 4'b1001));
    repeat (40) @(negedge clk);
    wr(2, fld(1, 4'b1000));
    rd(5 + 3*1, cnt_a);
    d = pwm[1];
    repeat (30) @(negedge clk);
    rd(5 + 3*1, cnt_b);
    chk("R7", "counter frozen when stopped", cnt_b, cnt_a);
    chk("R7", "output held when stopped", int'(pwm[1]), d);
    chk("R7", "counter had moved before stop", int'(cnt_a < 200 && cnt_a > 100), 1);

    // R8 R12 control layout and invert
    wr(2, 32'h000F_FFFF);
    rd(2, d); chk("R8", "ch4 invert bit not writable (R12 layout)", d, 32'h000B_FFFF);
    wr(2, 0);
    wr(3, 0); wr(4, 0);
    wr(2, fld(0, 4'b0110));
    wr(2, fld(0, 4'b0100));
    chk("R8", "ch0 inverted idle level", int'(pwm[0]), 1);
    wr(2, 0);
    chk("R8", "ch0 non-inverted idle level", int'(pwm[0]), 0);

    // R6 one-shot on ch2
    wr(3 + 3*2, 4); wr(4 + 3*2, 2);
    wr(2, fld(2, 4'b0010));
    wr(2, fld(2, 4'b0001));
    npulse = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (expire[2]) npulse++;
    end
    chk("R6", "one-shot pulse count", npulse, 1);
    rd(5 + 3*2, d); chk("R6", "one-shot parks at zero", d, 0);
    wr(2, 0);

    // R2 prescaler grouping: group A=0, group B=3, all dividers 0
    wr(0, 32'h0000_0300); wr(1, 0);
    wr(3, 3); wr(4, 0);
    wr(3 + 3*2, 3); wr(4 + 3*2, 0);
    wr(3 + 3*4, 3);
    wr(2, fld(0, 4'b1010) | fld(2, 4'b1010) | fld(4, 4'b1010));
    wr(2, fld(0, 4'b1001) | fld(2, 4'b1001) | fld(4, 4'b1001));
    measure(0, per, hi); chk("R2", "ch0 period in group A", per, 4);
    measure(2, per, hi); chk("R2", "ch2 period in group B", per, 16);
    measure(4, per, hi); chk("R2", "ch4 period in group B", per, 16);
    wr(2, 0);

    // R3 R4 R8 R10 sweep over channels, prescale, divider, count, duty, invert
    for (int ch = 0; ch < 4; ch++)
      for (int p = 0; p < 3; p += 2)
        for (int n = 0; n < 2; n++)
          for (int cn = 3; cn <= 5; cn += 2)
            for (int du = 0; du <= cn; du += (cn + 1) / 2) begin
              int inv;
              inv = (du == cn) ? 1 : 0;
              tp = (p + 1) * (1 << n);
              wr(2, 0);
              wr(0, p | (p << 8));
              wr(1, n | (n << 4) | (n << 8) | (n << 12) | (n << 16));
              wr(3 + 3*ch, cn);
              wr(4 + 3*ch, cn - du);
              wr(2, fld(ch, 4'b1010 | (inv << 2)));
              wr(2, fld(ch, 4'b1001 | (inv << 2)));
              measure(ch, per, hi);
              chk("R3", $sformatf("ch%0d p%0d n%0d N%0d period", ch, p, n, cn),
                  per, (cn + 1) * tp);
              chk(inv ? "R8" : "R4", $sformatf("ch%0d N%0d D%0d inv%0d high cycles", ch, cn, du, inv),
                  hi, inv ? (cn + 1 - du) * tp : du * tp);
              if (tp > 1) begin
                @(negedge clk);
                chk("R10", "pulse width one cycle", int'(expire[ch]), 0);
              end
            end
    wr(2, 0);

    // R9 channel 4 full-length countdown
    wr(0, 0); wr(1, 0);
    wr(3 + 3*4, (1 << CNT_W) - 1);
    wr(2, fld(4, 4'b1010));
    wr(2, fld(4, 4'b1001));
    measure(4, per, hi);
    chk("R9", "ch4 free-running period", per, 1 << CNT_W);
    wr(2, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule